// File: doc/BRIEF.md
# Masked interrupt factor controller

This block gathers single-cycle event pulses from peripherals into nibble-wide pending-flag registers. Each flag register has a companion enable register. From these it forms a maskable interrupt request and a non-maskable request for a 4-bit CPU. Software reads and writes the registers over a nibble-wide register port that decodes addresses in the top page. A pending flag stays set until software writes a 1 to its bit position, so an event that is not cleared raises the request again each time the CPU reopens interrupts.

Both requests, the non-maskable one included, are held low until the CPU reports that it has written both stack pointers. The CPU reports each write with its own one-cycle strobe. Once the pair is complete, a strobe for only one of the two pointers blocks everything again until the other pointer is also written.

Top module: `irq_factor_ctrl`

## Requirements
- R1: A peripheral pulse on `evt_i` sets the matching flag bit on the next clock edge, whatever the value of the enable bit. Bits 3..0 of `evt_i` feed bank 0 and bits 7..4 feed bank 1.
- R2: A write of data D to a flag register clears each flag bit where D has a 1. Bits where D has a 0 keep their value.
- R3: When a pulse and a write-1 clear reach the same flag bit in the same cycle, the bit ends up set.
- R4: The address map is as follows: flags of bank b at 0xF8+b, enables of bank b at 0xF0+b, and every other address reads 0. `bus_rdata` shows the value the addressed register held before the edge, and it shows it one cycle after the address is presented.
- R5: After a synchronous reset, all flags and enable bits are 0, `irq_o` and `nmi_o` are 0, and the stack-pointer pair counts as unwritten.
- R6: `irq_o` is registered. It equals the OR over all bits of (flag AND enable), ANDed with `int_en_i` and with the pair-ready state, all taken from the previous cycle.
- R7: A flag that is not cleared keeps its request alive. `irq_o` returns as soon as `int_en_i` is raised again.
- R8: After reset, `irq_o` and `nmi_o` stay 0 until both `sp1_wr_i` and `sp2_wr_i` have been seen. The two strobes may come in either order or together.
- R9: Once the pair is ready, a strobe on only one of the two lines blocks both requests until the other line strobes. Both strobes in the same cycle keep the pair ready.
- R10: `nmi_o` is registered and equals `nmi_req_i` ANDed with the pair-ready state, both from the previous cycle.
- R11: Bank 1 implements only bits 1..0. Its bits 3..2 read 0 in both the flag and enable registers, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data |
| evt_i | input | 8 | Peripheral event pulses, bank b in bits 4b+3..4b |
| int_en_i | input | 1 | CPU interrupt-enable state |
| nmi_req_i | input | 1 | Non-maskable request input |
| sp1_wr_i | input | 1 | Strobe: first stack pointer written |
| sp2_wr_i | input | 1 | Strobe: second stack pointer written |
| irq_o | output | 1 | Maskable interrupt request |
| nmi_o | output | 1 | Gated non-maskable request |

## Verification
A flag bit stuck at the wrong value shows up on `bus_rdata` one cycle after a read of its address. When its enable bit is set, it also shows up on `irq_o` one cycle after the edge where it went wrong. A wrong pair-ready state shows up on `nmi_o` within one cycle whenever `nmi_req_i` is high, and on `irq_o` whenever any enabled flag is pending. The bench therefore keeps `nmi_req_i` and `int_en_i` high much of the time and interleaves stack-pointer strobes with register traffic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Arming state of the stack-pointer pair interlock
  typedef struct packed {
    logic sp1_seen;
    logic sp2_seen;
  } sp_arm_t;

  function automatic logic pair_ready(input sp_arm_t a);
    return a.sp1_seen & a.sp2_seen;
  endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int DATA_W = 4,
  parameter logic [DATA_W-1:0] USED = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt,
  input  logic              flag_we,
  input  logic              mask_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] flag_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              hit
);
  logic [DATA_W-1:0] clr;
  logic [DATA_W-1:0] flag_d;

  assign clr    = flag_we ? wdata : '0;
  // set dominates clear so no event is lost
  assign flag_d = ((flag_q & ~clr) | evt) & USED;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (mask_we) mask_q <= wdata & USED;
    end
  end

  assign hit = |(flag_q & mask_q);

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & $past(evt & USED)) == $past(evt & USED))); // R1

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0)); // R2

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2
endmodule

// File: rtl/irqc_sp_interlock.sv
module irqc_sp_interlock
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sp1_wr,
  input  logic sp2_wr,
  output logic ready
);
  sp_arm_t arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (pair_ready(arm_q)) begin
      // a lone write re-opens the pair: the other half must follow
      if (sp1_wr && !sp2_wr) arm_d.sp2_seen = 1'b0;
      if (sp2_wr && !sp1_wr) arm_d.sp1_seen = 1'b0;
    end else begin
      arm_d.sp1_seen = arm_q.sp1_seen | sp1_wr;
      arm_d.sp2_seen = arm_q.sp2_seen | sp2_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) arm_q <= '0;
    else     arm_q <= arm_d;
  end

  assign ready = pair_ready(arm_q);

  AST_LONE_STROBE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (ready && (sp1_wr != sp2_wr)) |=> !ready); // R9

  AST_PAIR_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (ready && sp1_wr && sp2_wr) |=> ready); // R9

  AST_READY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!ready && !sp1_wr && !sp2_wr) |=> !ready); // R8
endmodule

// File: rtl/irqc_req_gen.sv
module irqc_req_gen #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ready,
  input  logic                 int_en,
  input  logic                 nmi_req,
  input  logic [NUM_BANKS-1:0] hits,
  output logic                 irq_o,
  output logic                 nmi_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      nmi_o <= 1'b0;
    end else begin
      irq_o <= ready & int_en & (|hits);
      nmi_o <= ready & nmi_req;
    end
  end

  AST_IRQ_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !irq_o); // R8

  AST_NMI_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !nmi_o); // R10

  AST_PENDING_REFIRES: assert property (@(posedge clk) disable iff (rst)
    (ready && int_en && (|hits)) |=> irq_o); // R7
endmodule

// File: rtl/irq_factor_ctrl.sv
module irq_factor_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 4,
  parameter int NUM_BANKS = 2,
  parameter int MASK_BASE = 'hF0,
  parameter int FLAG_BASE = 'hF8,
  parameter logic [NUM_BANKS*DATA_W-1:0] USED_BITS = 8'h3F
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*DATA_W-1:0] evt_i,
  input  logic                        int_en_i,
  input  logic                        nmi_req_i,
  input  logic                        sp1_wr_i,
  input  logic                        sp2_wr_i,
  output logic                        irq_o,
  output logic                        nmi_o
);
  localparam int EVT_W = NUM_BANKS * DATA_W;

  logic [NUM_BANKS-1:0] flag_sel, mask_sel, hits;
  logic [EVT_W-1:0]     flag_all, mask_all;
  logic [DATA_W-1:0]    rd_mux;
  logic                 ready;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign flag_sel[b] = (bus_addr == ADDR_W'(FLAG_BASE + b));
    assign mask_sel[b] = (bus_addr == ADDR_W'(MASK_BASE + b));

    irqc_flag_bank #(
      .DATA_W (DATA_W),
      .USED   (USED_BITS[b*DATA_W +: DATA_W])
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_i[b*DATA_W +: DATA_W]),
      .flag_we (bus_wr & flag_sel[b]),
      .mask_we (bus_wr & mask_sel[b]),
      .wdata   (bus_wdata),
      .flag_q  (flag_all[b*DATA_W +: DATA_W]),
      .mask_q  (mask_all[b*DATA_W +: DATA_W]),
      .hit     (hits[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (flag_sel[b]) rd_mux = flag_all[b*DATA_W +: DATA_W];
      if (mask_sel[b]) rd_mux = mask_all[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  irqc_sp_interlock u_lock (
    .clk    (clk),
    .rst    (rst),
    .sp1_wr (sp1_wr_i),
    .sp2_wr (sp2_wr_i),
    .ready  (ready)
  );

  irqc_req_gen #(.NUM_BANKS(NUM_BANKS)) u_req (
    .clk     (clk),
    .rst     (rst),
    .ready   (ready),
    .int_en  (int_en_i),
    .nmi_req (nmi_req_i),
    .hits    (hits),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o)
  );

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~(USED_BITS[2*DATA_W-1:DATA_W]) & {DATA_W{1'b1}}) == '0
    || !$past(flag_sel[1] || mask_sel[1])); // R11
endmodule

// File: tb/irq_factor_ctrl_test.sv
module irq_factor_ctrl_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [3:0] bus_wdata;
  logic [3:0] bus_rdata;
  logic [7:0] evt_i;
  logic       int_en_i, nmi_req_i, sp1_wr_i, sp2_wr_i;
  logic       irq_o, nmi_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_flag [2];
  logic [3:0] m_mask [2];
  logic       m_arm1, m_arm2;
  logic [3:0] e_rd;
  logic       e_irq, e_nmi;

  localparam logic [3:0] USED [2] = '{4'hF, 4'h3};

  always #2 clk = ~clk;

  irq_factor_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .int_en_i(int_en_i), .nmi_req_i(nmi_req_i), .sp1_wr_i(sp1_wr_i),
    .sp2_wr_i(sp2_wr_i), .irq_o(irq_o), .nmi_o(nmi_o)
  );

  function automatic logic [3:0] model_read(input logic [7:0] a);
    if (a == 8'hF8) return m_flag[0];
    if (a == 8'hF9) return m_flag[1];
    if (a == 8'hF0) return m_mask[0];
    if (a == 8'hF1) return m_mask[1];
    return 4'h0;
  endfunction

  function automatic logic model_irq();
    return m_arm1 & m_arm2 & int_en_i &
           (|(m_flag[0] & m_mask[0]) | |(m_flag[1] & m_mask[1]));
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; compute expectation, update model, compare
  task automatic step(input string tag);
    logic rdy;
    e_rd  = model_read(bus_addr);
    e_irq = model_irq();
    rdy   = m_arm1 & m_arm2;
    e_nmi = rdy & nmi_req_i;
    for (int b = 0; b < 2; b++) begin
      logic [3:0] c;
      c = (bus_wr && bus_addr == 8'(8'hF8 + b)) ? bus_wdata : 4'h0;
      m_flag[b] = ((m_flag[b] & ~c) | evt_i[b*4 +: 4]) & USED[b];
      if (bus_wr && bus_addr == 8'(8'hF0 + b)) m_mask[b] = bus_wdata & USED[b];
    end
    if (rdy) begin
      if (sp1_wr_i && !sp2_wr_i) m_arm2 = 1'b0;
      if (sp2_wr_i && !sp1_wr_i) m_arm1 = 1'b0;
    end else begin
      m_arm1 = m_arm1 | sp1_wr_i;
      m_arm2 = m_arm2 | sp2_wr_i;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " R4 rdata"}, bus_rdata, e_rd);
    check({tag, " R6 irq"}, {3'b0, irq_o}, {3'b0, e_irq});
    check({tag, " R10 nmi"}, {3'b0, nmi_o}, {3'b0, e_nmi});
  endtask

  task automatic idle();
    bus_wr = 0; bus_wdata = 0; evt_i = 0; sp1_wr_i = 0; sp2_wr_i = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1; idle(); bus_addr = 0; int_en_i = 0; nmi_req_i = 0;
    m_flag = '{4'h0, 4'h0}; m_mask = '{4'h0, 4'h0}; m_arm1 = 0; m_arm2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R5: reset state at the ports
    check("R5 irq after reset", {3'b0, irq_o}, 4'h0);
    check("R5 nmi after reset", {3'b0, nmi_o}, 4'h0);
    foreach (USED[b]) begin
      bus_addr = 8'(8'hF8 + b); step("R5 flag reset");
      bus_addr = 8'(8'hF0 + b); step("R5 mask reset");
    end
    // R1 / R8: events with mask 0 still set flags; nothing fires before pair
    int_en_i = 1; nmi_req_i = 1;
    evt_i = 8'h35; bus_addr = 8'hF8; step("R1 set with mask off");
    idle(); step("R1 read bank0");
    check("R1 bank0 flags", bus_rdata, 4'h5);
    bus_addr = 8'hF0; bus_wr = 1; bus_wdata = 4'hF; step("R8 enable bank0");
    idle(); bus_addr = 8'hF1; bus_wr = 1; bus_wdata = 4'hF; step("R11 enable bank1");
    idle(); step("R11 read mask1");
    check("R11 mask1 upper bits", bus_rdata, 4'h3);
    check("R8 irq blocked before pair", {3'b0, irq_o}, 4'h0);
    sp1_wr_i = 1; step("R8 first strobe");
    idle(); step("R8 half pair");
    check("R8 nmi still blocked", {3'b0, nmi_o}, 4'h0);
    sp2_wr_i = 1; step("R8 second strobe");
    idle(); step("R8 pair ready");
    check("R8 nmi open", {3'b0, nmi_o}, 4'h1);
    check("R7 pending irq", {3'b0, irq_o}, 4'h1);
    // R7: drop and raise enable, request returns
    int_en_i = 0; step("R7 disable"); step("R7 disabled");
    check("R7 irq off", {3'b0, irq_o}, 4'h0);
    int_en_i = 1; step("R7 reenable"); step("R7 refire");
    check("R7 irq refires", {3'b0, irq_o}, 4'h1);
    // R9: lone strobe re-blocks
    sp2_wr_i = 1; step("R9 lone strobe");
    idle(); step("R9 blocked");
    check("R9 nmi blocked", {3'b0, nmi_o}, 4'h0);
    sp1_wr_i = 1; step("R9 other half");
    idle(); step("R9 reopened");
    check("R9 nmi reopened", {3'b0, nmi_o}, 4'h1);
    // R3: set and clear same bit same cycle
    bus_addr = 8'hF8; bus_wr = 1; bus_wdata = 4'h4; evt_i = 8'h04; step("R3 set vs clear");
    idle(); step("R3 read");
    check("R3 set wins", bus_rdata, 4'h5);
    // R2: write-0 keeps, write-1 clears
    bus_wr = 1; bus_wdata = 4'h0; step("R2 write zero");
    idle(); bus_wr = 1; bus_wdata = 4'h1; step("R2 clear bit0");
    idle(); step("R2 read");
    check("R2 cleared bit0", bus_rdata, 4'h4);
    // R4: unmapped address reads 0
    bus_addr = 8'hF5; step("R4 unmapped"); step("R4 unmapped read");
    check("R4 unmapped zero", bus_rdata, 4'h0);
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      idle();
      pick = 3'($urandom_range(0, 5));
      case (pick)
        0: bus_addr = 8'hF0; 1: bus_addr = 8'hF1;
        2: bus_addr = 8'hF8; 3: bus_addr = 8'hF9;
        default: bus_addr = 8'($urandom);
      endcase
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_wdata = 4'($urandom);
      evt_i     = ($urandom_range(0, 4) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      int_en_i  = ($urandom_range(0, 3) != 0);
      nmi_req_i = ($urandom_range(0, 2) != 0);
      sp1_wr_i  = ($urandom_range(0, 15) == 0);
      sp2_wr_i  = ($urandom_range(0, 15) == 0);
      step("random R1 R2 R3 R9");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule